// File: doc/BRIEF.md
# Entropy Sampling and Bias Correction Pipeline

This block conditions the raw output of a set of free-running entropy sources into a true-random bit stream. A single combined source bit is captured at a programmable rate. Consecutive captures are folded into "reduced" bits, and a programmable warm-up window of captures is discarded after each start. An optional pair corrector then removes any constant bias from the reduced stream. The oscillators themselves lie outside the block.

Software programs the sample divider, the group length, the warm-up length and the corrector enable, then raises `run_i`. A one-cycle `init_pulse_o` marks the end of the warm-up window. Random bits then arrive on `rnd_valid_o`/`rnd_bit_o` at an irregular pace. A health monitor may raise `stop_req_i`, which halts the pipeline until `run_i` is lowered. The raw, reduced and final streams are also tapped out for that monitor.

Top module: `entropy_conditioner`

## Requirements
- R1: With sample divider value N, while running the source bit is captured on active clock edges k (counted from 0 at the first running edge) where k mod (N+1) equals N. The capture appears on `tap_raw_vld_o`/`tap_raw_o` after that edge.
- R2: With group length value G, each reduced bit is the XOR of G+1 consecutive kept captures. Groups do not overlap, and the first group starts with the first capture after the warm-up window.
- R3: With warm-up value W, the first W+1 captures after a start are discarded and never contribute to a reduced bit. The typical setting is 3.
- R4: `init_pulse_o` is high for exactly one cycle, after the edge that follows the edge that captured the last discarded sample. It occurs at most once per run.
- R5: With `vn_en_i` = 1, reduced bits are taken in non-overlapping pairs (older, newer). Pair 0,1 emits 0; pair 1,0 emits 1; pairs 0,0 and 1,1 emit nothing. A bit is emitted after the edge following the newer bit's reduced-tap cycle.
- R6: With `vn_en_i` = 0, every reduced bit is forwarded to `rnd_valid_o`/`rnd_bit_o` one cycle after it appears on the reduced tap.
- R7: `stop_req_i` sampled high while `run_i` is high lets that edge complete. From the next edge the pipeline is halted with all strobes low, and it stays halted until `run_i` is lowered.
- R8: Lowering `run_i` clears the divider, warm-up, group and pair state, so the next start begins a fresh warm-up window with a new `init_pulse_o`.
- R9: A capture that completes a group shows on the reduced tap one cycle after its raw tap cycle.
- R10: After reset all output strobes and data bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable |
| stop_req_i | input | 1 | Halt request from the health monitor |
| raw_bit_i | input | 1 | Combined entropy source bit |
| smp_div_i | input | SMP_DIV_W | Sample divider value N (rate = clk/(N+1)) |
| grp_len_i | input | GRP_W | Captures per reduced bit, minus one |
| warmup_i | input | WARM_W | Discarded captures after start, minus one |
| vn_en_i | input | 1 | Pair corrector enable |
| rnd_valid_o | output | 1 | Output random bit strobe |
| rnd_bit_o | output | 1 | Output random bit |
| init_pulse_o | output | 1 | One-cycle end-of-warm-up pulse |
| tap_raw_vld_o | output | 1 | Raw capture strobe |
| tap_raw_o | output | 1 | Raw capture bit |
| tap_red_vld_o | output | 1 | Reduced bit strobe |
| tap_red_o | output | 1 | Reduced bit |

## Verification
On every cycle the assertions check the halt timing and the quiet state of an idle pipeline, the single-cycle init pulse, the absence of reduced bits before warm-up has ended, and the stage-to-stage timing of the bypass and corrector paths. The values themselves are shown only by the bench scenarios: the XOR folding of each group, the exact edge of every capture for several divider settings, the pair decoding and the fresh warm-up after a restart. The bench scores these against a model built from the requirements.

// File: rtl/ent_pkg.sv
package ent_pkg;
   typedef struct packed {
      logic vld;
      logic dat;
   } ent_beat_t;
endpackage

// File: rtl/ent_sampler.sv
module ent_sampler
   import ent_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [DIV_W-1:0] div_i,
   input  logic             raw_i,
   output ent_beat_t        smp_o
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         smp_o <= '0;
      end else if (!active) begin
         cnt_q <= '0;
         smp_o <= '0;
      end else if (cnt_q >= div_i) begin
         cnt_q     <= '0;
         smp_o.vld <= 1'b1;
         smp_o.dat <= raw_i;
      end else begin
         cnt_q     <= cnt_q + 1'b1;
         smp_o.vld <= 1'b0;
      end
   end
endmodule

// File: rtl/ent_reducer.sv
module ent_reducer
   import ent_pkg::*;
#(
   parameter int GRP_W  = 8,
   parameter int WARM_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  ent_beat_t         smp_i,
   input  logic [GRP_W-1:0]  grp_len_i,
   input  logic [WARM_W-1:0] warmup_i,
   output ent_beat_t         red_o,
   output logic              init_pulse_o
);
   logic [WARM_W-1:0] drop_q;
   logic              armed_q;
   logic [GRP_W-1:0]  grp_q;
   logic              acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drop_q       <= '0;
         armed_q      <= 1'b0;
         grp_q        <= '0;
         acc_q        <= 1'b0;
         red_o        <= '0;
         init_pulse_o <= 1'b0;
      end else if (!active) begin
         drop_q       <= '0;
         armed_q      <= 1'b0;
         grp_q        <= '0;
         acc_q        <= 1'b0;
         red_o        <= '0;
         init_pulse_o <= 1'b0;
      end else begin
         red_o.vld    <= 1'b0;
         init_pulse_o <= 1'b0;
         if (smp_i.vld) begin
            if (!armed_q) begin
               if (drop_q >= warmup_i) begin
                  armed_q      <= 1'b1;
                  init_pulse_o <= 1'b1;
               end else begin
                  drop_q <= drop_q + 1'b1;
               end
            end else if (grp_q >= grp_len_i) begin
               red_o.vld <= 1'b1;
               red_o.dat <= acc_q ^ smp_i.dat;
               acc_q     <= 1'b0;
               grp_q     <= '0;
            end else begin
               acc_q <= acc_q ^ smp_i.dat;
               grp_q <= grp_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ent_corrector.sv
module ent_corrector
   import ent_pkg::*;
#(
   parameter bit HAS_VN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      active,
   input  logic      vn_en_i,
   input  ent_beat_t red_i,
   output ent_beat_t out_o
);
   generate
      if (HAS_VN) begin : g_pair
         logic have_q;
         logic old_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               have_q <= 1'b0;
               old_q  <= 1'b0;
               out_o  <= '0;
            end else if (!active) begin
               have_q <= 1'b0;
               old_q  <= 1'b0;
               out_o  <= '0;
            end else if (!vn_en_i) begin
               have_q <= 1'b0;
               out_o  <= red_i;
            end else begin
               out_o.vld <= 1'b0;
               if (red_i.vld) begin
                  if (!have_q) begin
                     have_q <= 1'b1;
                     old_q  <= red_i.dat;
                  end else begin
                     have_q    <= 1'b0;
                     out_o.vld <= old_q ^ red_i.dat;
                     out_o.dat <= old_q;
                  end
               end
            end
         end
      end else begin : g_bypass
         logic unused_vn;
         assign unused_vn = vn_en_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_o <= '0;
            end else if (!active) begin
               out_o <= '0;
            end else begin
               out_o <= red_i;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/entropy_conditioner.sv
module entropy_conditioner
   import ent_pkg::*;
#(
   parameter int SMP_DIV_W = 8,
   parameter int GRP_W     = 8,
   parameter int WARM_W    = 8,
   parameter bit HAS_VN    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_i,
   input  logic                 stop_req_i,
   input  logic                 raw_bit_i,
   input  logic [SMP_DIV_W-1:0] smp_div_i,
   input  logic [GRP_W-1:0]     grp_len_i,
   input  logic [WARM_W-1:0]    warmup_i,
   input  logic                 vn_en_i,
   output logic                 rnd_valid_o,
   output logic                 rnd_bit_o,
   output logic                 init_pulse_o,
   output logic                 tap_raw_vld_o,
   output logic                 tap_raw_o,
   output logic                 tap_red_vld_o,
   output logic                 tap_red_o
);
   localparam int CNT_BITS = SMP_DIV_W + GRP_W + WARM_W;

   generate
      if (SMP_DIV_W < 1 || GRP_W < 1 || WARM_W < 1 || CNT_BITS > 96) begin : g_bad_cfg
         $error("entropy_conditioner: counter widths must each be 1 or more and 96 in total at most");
      end
   endgenerate

   logic      halt_q;
   logic      active;
   ent_beat_t smp_b;
   ent_beat_t red_b;
   ent_beat_t out_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
      end else if (!run_i) begin
         halt_q <= 1'b0;
      end else if (stop_req_i) begin
         halt_q <= 1'b1;
      end
   end

   assign active = run_i & ~halt_q;

   ent_sampler #(.DIV_W(SMP_DIV_W)) u_smp (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .div_i  (smp_div_i),
      .raw_i  (raw_bit_i),
      .smp_o  (smp_b)
   );

   ent_reducer #(.GRP_W(GRP_W), .WARM_W(WARM_W)) u_red (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (active),
      .smp_i        (smp_b),
      .grp_len_i    (grp_len_i),
      .warmup_i     (warmup_i),
      .red_o        (red_b),
      .init_pulse_o (init_pulse_o)
   );

   ent_corrector #(.HAS_VN(HAS_VN)) u_cor (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .vn_en_i (vn_en_i),
      .red_i   (red_b),
      .out_o   (out_b)
   );

   assign tap_raw_vld_o = smp_b.vld;
   assign tap_raw_o     = smp_b.dat;
   assign tap_red_vld_o = red_b.vld;
   assign tap_red_o     = red_b.dat;
   assign rnd_valid_o   = out_b.vld;
   assign rnd_bit_o     = out_b.dat;
endmodule

// File: rtl/ent_conditioner_chk.sv
module ent_conditioner_chk (
   input logic clk,
   input logic rst_n,
   input logic run_i,
   input logic stop_req_i,
   input logic vn_en_i,
   input logic active,
   input logic rnd_valid_o,
   input logic init_pulse_o,
   input logic tap_raw_vld_o,
   input logic tap_red_vld_o,
   input logic tap_red_o,
   input logic rnd_bit_o
);
   logic warm_done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm_done_q <= 1'b0;
      end else if (!active) begin
         warm_done_q <= 1'b0;
      end else if (init_pulse_o) begin
         warm_done_q <= 1'b1;
      end
   end

   // R7: a stop request during a run halts the pipeline from the next edge
   a_r7_halt_next: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && stop_req_i) |=> !active);

   // R7: once halted, only lowering run releases the halt
   a_r7_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !active) |=> (!run_i || !active));

   // R8: an idle pipeline raises no strobe on the following cycle
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!rnd_valid_o && !tap_raw_vld_o && !tap_red_vld_o && !init_pulse_o));

   // R4: the end-of-warm-up pulse lasts one cycle
   a_r4_init_single: assert property (@(posedge clk) disable iff (!rst_n)
      init_pulse_o |=> !init_pulse_o);

   // R3: no reduced bit before the warm-up window has ended
   a_r3_no_early_red: assert property (@(posedge clk) disable iff (!rst_n)
      tap_red_vld_o |-> (warm_done_q || init_pulse_o));

   // R5: in corrector mode an output follows a reduced bit one cycle earlier
   a_r5_pair_source: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_valid_o && $past(vn_en_i)) |-> $past(tap_red_vld_o));

   // R6: bypass mode forwards each reduced bit one cycle later
   a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!vn_en_i) && $past(active)) |->
         (rnd_valid_o == $past(tap_red_vld_o)) && (!rnd_valid_o || rnd_bit_o == $past(tap_red_o)));
endmodule

bind entropy_conditioner ent_conditioner_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .run_i         (run_i),
   .stop_req_i    (stop_req_i),
   .vn_en_i       (vn_en_i),
   .active        (active),
   .rnd_valid_o   (rnd_valid_o),
   .init_pulse_o  (init_pulse_o),
   .tap_raw_vld_o (tap_raw_vld_o),
   .tap_red_vld_o (tap_red_vld_o),
   .tap_red_o     (tap_red_o),
   .rnd_bit_o     (rnd_bit_o)
);

// File: tb/sim_entropy_conditioner.sv
module sim_entropy_conditioner;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       run_i = 1'b0;
   logic       stop_req_i = 1'b0;
   logic       raw_bit_i = 1'b0;
   logic [7:0] smp_div_i = '0;
   logic [7:0] grp_len_i = '0;
   logic [7:0] warmup_i = '0;
   logic       vn_en_i = 1'b0;
   logic       rnd_valid_o, rnd_bit_o, init_pulse_o;
   logic       tap_raw_vld_o, tap_raw_o, tap_red_vld_o, tap_red_o;

   always #5 clk = ~clk;

   entropy_conditioner u0 (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .stop_req_i(stop_req_i),
      .raw_bit_i(raw_bit_i), .smp_div_i(smp_div_i), .grp_len_i(grp_len_i),
      .warmup_i(warmup_i), .vn_en_i(vn_en_i), .rnd_valid_o(rnd_valid_o),
      .rnd_bit_o(rnd_bit_o), .init_pulse_o(init_pulse_o),
      .tap_raw_vld_o(tap_raw_vld_o), .tap_raw_o(tap_raw_o),
      .tap_red_vld_o(tap_red_vld_o), .tap_red_o(tap_red_o)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    edge_n = 0;
   bit    mon_on = 1'b0;
   bit    done = 1'b0;
   int    q_edge[$];
   bit    q_bit[$];
   int    init_exp;
   int    n_init;
   int    n_out;
   string tags;
   logic [15:0] lfsr = 16'hACE1;
   // model state
   int    m_nsamp, m_gpos;
   bit    m_acc, m_have, m_old;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard monitor: outputs after edge e
   always begin
      @(posedge clk);
      #1;
      if (mon_on) begin
         automatic int e = edge_n;
         edge_n++;
         if (rnd_valid_o) begin
            n_out++;
            if (q_edge.size() == 0) begin
               check(1'b0, {tags, " unexpected bit"}, e, -1);
            end else begin
               automatic int ee = q_edge.pop_front();
               automatic bit eb = q_bit.pop_front();
               check(ee == e && eb == rnd_bit_o, tags, e * 2 + int'(rnd_bit_o), ee * 2 + int'(eb));
            end
         end
         if (init_pulse_o) begin
            n_init++;
            check(e == init_exp, "R4 init edge", e, init_exp);
         end
      end
   end

   // requirement model of one capture at edge k
   task automatic model_sample(input bit b, input int k, input int rd, input int dl, input bit vn);
      if (m_nsamp <= dl) begin
         if (m_nsamp == dl) init_exp = k + 1;
         m_nsamp++;
      end else begin
         m_acc ^= b;
         m_gpos++;
         if (m_gpos == rd + 1) begin
            automatic bit r = m_acc;
            m_acc  = 1'b0;
            m_gpos = 0;
            if (!vn) begin
               q_edge.push_back(k + 2);
               q_bit.push_back(r);
            end else if (!m_have) begin
               m_have = 1'b1;
               m_old  = r;
            end else begin
               m_have = 1'b0;
               if (m_old != r) begin
                  q_edge.push_back(k + 2);
                  q_bit.push_back(m_old);
               end
            end
         end
      end
   endtask

   // driver: one run with a given setting
   task automatic run_case(input int dv, input int rd, input int dl, input bit vn,
                           input bit use_pat, input logic [15:0] pat,
                           input int cycles, input int stop_at, input string tg);
      int  last;
      bit  live;
      @(negedge clk);
      smp_div_i = 8'(dv);
      grp_len_i = 8'(rd);
      warmup_i  = 8'(dl);
      vn_en_i   = vn;
      q_edge.delete();
      q_bit.delete();
      m_nsamp = 0; m_gpos = 0; m_acc = 0; m_have = 0; m_old = 0;
      init_exp = -1; n_init = 0; n_out = 0; tags = tg;
      edge_n = 0; last = -1; live = 1'b1;
      run_i = 1'b1; mon_on = 1'b1;
      for (int c = 0; c < cycles; c++) begin
         automatic bit b = use_pat ? pat[c % 16] : lfsr[0];
         automatic int k = edge_n;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         raw_bit_i = b;
         if (c == stop_at) begin
            stop_req_i = 1'b1;
            last = k;
         end
         if (live && (k % (dv + 1)) == dv) model_sample(b, k, rd, dl, vn);
         if (c == stop_at) live = 1'b0;
         @(negedge clk);
      end
      if (last < 0) last = edge_n - 1;
      run_i = 1'b0;
      stop_req_i = 1'b0;
      repeat (3) @(negedge clk);
      while (q_edge.size() > 0) begin
         automatic int ee = q_edge.pop_front();
         void'(q_bit.pop_front());
         if (ee <= last) check(1'b0, {tg, " missing bit"}, -1, ee);
      end
      check(1'b1, {tg, " drained"}, 0, 0);
      check(n_init == ((init_exp >= 0 && init_exp <= last) ? 1 : 0), "R4 R8 init count",
            n_init, (init_exp >= 0 && init_exp <= last) ? 1 : 0);
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      check({rnd_valid_o, rnd_bit_o, init_pulse_o, tap_raw_vld_o, tap_raw_o,
             tap_red_vld_o, tap_red_o} == 7'd0, "R10 reset outputs",
            int'({rnd_valid_o, init_pulse_o, tap_raw_vld_o, tap_red_vld_o}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R5: pairs 01,10,00,11 after one dropped capture
      run_case(0, 0, 0, 1'b1, 1'b1, 16'h018D, 9, -1, "R5 pair decode");
      check(n_out == 2, "R5 pair count", n_out, 2);
      run_case(0, 0, 3, 1'b0, 1'b0, 16'h0, 60, -1, "R1 R2 R3 R6 R9 div0");
      run_case(2, 1, 1, 1'b0, 1'b0, 16'h0, 80, -1, "R1 R2 R3 R6 div2 grp2");
      run_case(1, 3, 2, 1'b1, 1'b0, 16'h0, 200, -1, "R2 R5 div1 grp4");
      run_case(0, 2, 3, 1'b1, 1'b0, 16'h0, 300, -1, "R2 R5 grp3");
      // R7: stop request mid-run, run held high afterwards
      run_case(3, 0, 5, 1'b0, 1'b0, 16'h0, 100, 40, "R7 halt");
      // R8: restart after halt begins a fresh warm-up
      run_case(0, 0, 1, 1'b0, 1'b0, 16'h0, 30, -1, "R8 restart");
      run_case(255, 0, 1, 1'b0, 1'b0, 16'h0, 1300, -1, "R1 max divider");
      run_case(0, 0, 255, 1'b0, 1'b0, 16'h0, 300, -1, "R3 max warm-up");
      mon_on = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule